// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block connects a host to a small serial EEPROM of 64 sixteen-bit words. The EEPROM uses four pins: chip select, serial clock, data into the memory, and data out of the memory. The host places a one-cycle request with a direction bit, a 6-bit word address and a 16-bit write word. The block then runs the whole pin sequence by itself. When the sequence is over it returns a one-cycle acknowledge.

A read sends a command frame and clocks sixteen data bits back, most significant bit first. A write has more steps. It first enables writing in the memory, then sends the address and the data word. It then polls the memory's data-out pin until the internal programming cycle ends or a bounded number of samples has passed. It finishes by disabling writing again and releasing the bus.

Every pin level is held for one interval of `HALF_CYC` system clock cycles. At a 200 MHz clock the default of 10000 cycles gives 50 us per interval.

Top module: `seeprom_master`

## Requirements
- R1: After reset, and whenever no request is in progress, chip select, serial clock, data-in and acknowledge are all low.
- R2: Every pin configuration of a sequence is held for exactly `HALF_CYC` clock cycles. The first configuration begins in the cycle after the clock edge that accepts the request.
- R3: Frames are shifted out most significant bit first. Each bit takes three intervals with chip select high: the bit with clock low, the same bit with clock high, and the same bit with clock low. Data-in is low in every interval outside a shift-out.
- R4: Every command starts with one interval with all pins low, followed by one interval with only chip select high.
- R5: A read sends the 9-bit frame `110` followed by the address. It then takes sixteen bits, each as one interval with the clock high and one with the clock low. Data-out is sampled at the end of each high interval, and the first sample is the most significant bit.
- R6: A standby sequence is four intervals in this order: (select low, clock low), (select low, clock high), (select high, clock high), (select high, clock low). A read ends with one standby sequence.
- R7: A write runs these steps in order:
  - the enable frame `10011` followed by 4 zero bits;
  - a standby sequence;
  - the 25-bit frame `101`, address, data;
  - a standby sequence;
  - the busy poll;
  - a standby sequence;
  - the disable frame `10000` followed by 4 zero bits;
  - cleanup.
- R8: During the busy poll, chip select is high and clock and data-in are low. Data-out is sampled at the end of each interval. The poll ends at the first high sample. If `POLL_MAX` samples (default 200) are all low, the timeout flag is set and the write continues.
- R9: Cleanup drops chip select with data-in low, then gives one clock pulse: intervals (select low, clock low), (select low, clock high), (select low, clock low).
- R10: The acknowledge is high for exactly one cycle, in the cycle after the last interval. With it, the read data output carries the word read (zero for a write), and the timeout output carries the timeout result (zero for a read).
- R11: A request is accepted only while the block is idle. The direction, address and write word are captured at acceptance, and requests made during a sequence are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Word to write |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Word read, valid with ack_o |
| timeout_o | output | 1 | Busy poll expired, valid with ack_o |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data into the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
The assertions assume that reset is released away from a clock edge. They also assume that data-out is stable around the edge that ends a sampling interval, because the pin is sampled directly with no synchronizer. The bench memory model changes data-out only on the falling system clock edge. The host drives its request inputs on the falling edge, and the bench issues a request during a running read to confirm that such requests are dropped.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE, SEG_SETUP, SEG_SHOUT, SEG_SHIN, SEG_STBY, SEG_POLL, SEG_CLEAN
  } seg_e;

  // Command codes, leading start bit included
  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam logic [2:0] OPC_WRITE = 3'b101;
  localparam logic [4:0] OPC_WREN  = 5'b10011;
  localparam logic [4:0] OPC_WRDIS = 5'b10000;

  // Segment that runs at a given stage of a read or write
  function automatic seg_e seg_for(input logic wr, input logic [3:0] stage);
    seg_e s;
    s = SEG_IDLE;
    if (!wr) begin
      case (stage)
        4'd0: s = SEG_SETUP;
        4'd1: s = SEG_SHOUT;
        4'd2: s = SEG_SHIN;
        4'd3: s = SEG_STBY;
        default: s = SEG_IDLE;
      endcase
    end else begin
      case (stage)
        4'd0: s = SEG_SETUP;
        4'd1: s = SEG_SHOUT;
        4'd2: s = SEG_STBY;
        4'd3: s = SEG_SHOUT;
        4'd4: s = SEG_STBY;
        4'd5: s = SEG_POLL;
        4'd6: s = SEG_STBY;
        4'd7: s = SEG_SHOUT;
        4'd8: s = SEG_CLEAN;
        default: s = SEG_IDLE;
      endcase
    end
    return s;
  endfunction

  // Index of the final interval within one unit of a segment
  function automatic logic [1:0] last_phase(input seg_e s);
    logic [1:0] p;
    case (s)
      SEG_SETUP: p = 2'd1;
      SEG_SHOUT: p = 2'd2;
      SEG_SHIN:  p = 2'd1;
      SEG_STBY:  p = 2'd3;
      SEG_CLEAN: p = 2'd2;
      default:   p = 2'd0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/seeprom_timer.sv
module seeprom_timer #(
  parameter int HALF_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == TOP);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seeprom_shreg.sv
module seeprom_shreg #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)       q_d = load_val;
    else if (shift) q_d = {q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/seeprom_pindec.sv
module seeprom_pindec
  import seeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seg_e       seg,
  input  logic [1:0] ph,
  input  logic       dbit,
  output logic       cs,
  output logic       sk,
  output logic       di
);
  always_comb begin
    cs = 1'b0;
    sk = 1'b0;
    di = 1'b0;
    case (seg)
      SEG_SETUP: cs = (ph == 2'd1);
      SEG_SHOUT: begin cs = 1'b1; sk = (ph == 2'd1); di = dbit; end
      SEG_SHIN:  begin cs = 1'b1; sk = (ph == 2'd0); end
      SEG_STBY:  begin cs = (ph >= 2'd2); sk = (ph == 2'd1) || (ph == 2'd2); end
      SEG_POLL:  cs = 1'b1;
      SEG_CLEAN: sk = (ph == 2'd1);
      default:   ;
    endcase
  end

  // R3
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sk) |-> $stable(di));
endmodule

// File: rtl/seeprom_master.sv
module seeprom_master
  import seeprom_pkg::*;
#(
  parameter int HALF_CYC = 10000,
  parameter int POLL_MAX = 200,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              timeout_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int CNT_MAX = (FRAME_W > POLL_MAX) ? FRAME_W : POLL_MAX;
  localparam int BW      = $clog2(CNT_MAX + 1);
  localparam int PAD_W   = ADDR_W - 2 + DATA_W;

  seg_e              seg_q, seg_d, nxt_seg;
  logic [3:0]        stage_q, stage_d, nxt_stage;
  logic [1:0]        ph_q, ph_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic              wr_q, wr_d, to_q, to_d, ack_q, ack_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic              tick, ld, sh, seg_end;
  logic [FRAME_W-1:0] ld_val, sr_q;

  seeprom_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(seg_q != SEG_IDLE), .tick(tick));

  seeprom_shreg #(.W(FRAME_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .shift(sh),
    .sin((seg_q == SEG_SHIN) && ee_do_i), .q(sr_q));

  seeprom_pindec u_pins (
    .clk(clk), .rst_n(rst_n), .seg(seg_q), .ph(ph_q), .dbit(sr_q[FRAME_W-1]),
    .cs(ee_cs_o), .sk(ee_sk_o), .di(ee_di_o));

  assign nxt_stage = stage_q + 4'd1;
  assign nxt_seg   = seg_for(wr_q, nxt_stage);

  // Frame to load when the next segment is a shift-out
  always_comb begin
    if (!wr_q)                ld_val = {OPC_READ, addr_q, {DATA_W{1'b0}}};
    else if (nxt_stage == 4'd1) ld_val = {OPC_WREN, {PAD_W{1'b0}}};
    else if (nxt_stage == 4'd3) ld_val = {OPC_WRITE, addr_q, wdata_q};
    else                      ld_val = {OPC_WRDIS, {PAD_W{1'b0}}};
  end

  always_comb begin
    seg_d = seg_q; stage_d = stage_q; ph_d = ph_q; bcnt_d = bcnt_q;
    wr_d = wr_q; addr_d = addr_q; wdata_d = wdata_q; to_d = to_q;
    rdata_d = rdata_q; ack_d = 1'b0; ld = 1'b0; sh = 1'b0; seg_end = 1'b0;
    if (seg_q == SEG_IDLE) begin
      if (req_i) begin
        seg_d = SEG_SETUP; stage_d = 4'd0; ph_d = 2'd0; bcnt_d = '0;
        wr_d = wr_i; addr_d = addr_i; wdata_d = wdata_i; to_d = 1'b0;
      end
    end else if (tick) begin
      sh = ((seg_q == SEG_SHOUT) && (ph_q == 2'd2)) ||
           ((seg_q == SEG_SHIN) && (ph_q == 2'd0));
      if (ph_q != last_phase(seg_q)) begin
        ph_d = ph_q + 2'd1;
      end else begin
        ph_d = 2'd0;
        case (seg_q)
          SEG_SHOUT, SEG_SHIN: begin
            if (bcnt_q == BW'(1)) seg_end = 1'b1;
            else                  bcnt_d = bcnt_q - 1'b1;
          end
          SEG_POLL: begin
            if (ee_do_i) seg_end = 1'b1;
            else if (bcnt_q == BW'(POLL_MAX - 1)) begin seg_end = 1'b1; to_d = 1'b1; end
            else bcnt_d = bcnt_q + 1'b1;
          end
          default: seg_end = 1'b1;
        endcase
      end
      if (seg_end) begin
        stage_d = nxt_stage; seg_d = nxt_seg; bcnt_d = '0;
        case (nxt_seg)
          SEG_SHOUT: begin
            ld = 1'b1;
            bcnt_d = (wr_q && (nxt_stage == 4'd3)) ? BW'(FRAME_W) : BW'(CMD_W);
          end
          SEG_SHIN: bcnt_d = BW'(DATA_W);
          SEG_IDLE: begin
            ack_d = 1'b1;
            rdata_d = wr_q ? '0 : sr_q[DATA_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_IDLE; stage_q <= '0; ph_q <= '0; bcnt_q <= '0;
      wr_q <= 1'b0; addr_q <= '0; wdata_q <= '0; to_q <= 1'b0;
      rdata_q <= '0; ack_q <= 1'b0;
    end else begin
      seg_q <= seg_d; stage_q <= stage_d; ph_q <= ph_d; bcnt_q <= bcnt_d;
      wr_q <= wr_d; addr_q <= addr_d; wdata_q <= wdata_d; to_q <= to_d;
      rdata_q <= rdata_d; ack_q <= ack_d;
    end
  end

  assign ack_o     = ack_q;
  assign rdata_o   = rdata_q;
  assign timeout_o = to_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_IDLE) |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));
  // R2
  pins_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable({ee_cs_o, ee_sk_o, ee_di_o}));
  // R8
  poll_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_POLL) |-> (ee_cs_o && !ee_sk_o && !ee_di_o));
  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
endmodule

// File: tb/seeprom_master_tb.sv
module seeprom_master_tb;
  timeunit 1ns; timeprecision 1ps;

  localparam int H = 2;
  localparam int POLL_N = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ack, tout, cs, sk, di;
  logic [15:0] rdata;
  logic m_do = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  bit chk_on = 1'b0;
  string tag = "R1";
  logic ecs = 0, esk = 0, edi = 0, eack = 0, eto = 0;
  logic [15:0] erd = '0;

  always #2.5 clk = ~clk;

  seeprom_master #(.HALF_CYC(H), .POLL_MAX(POLL_N), .ADDR_W(6), .DATA_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .timeout_o(tout),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(m_do));

  // ---------------- behavioural EEPROM model ----------------
  logic [15:0] mem [64];
  logic [24:0] sreg = '0;
  logic [15:0] outbuf = '0, pdata = '0;
  logic [5:0] paddr = '0;
  int cnt = 0, busy = 0, busy_len = 20;
  bit outmode = 0, wen = 0, pend = 0, stuck = 0, sk_prev = 0, cs_prev = 0;

  always @(negedge clk) begin
    if (busy > 0) busy--;
    if (cs && !cs_prev) begin cnt = 0; outmode = 0; end
    if (!cs && cs_prev) begin
      if (pend) begin mem[paddr] = pdata; pend = 0; busy = busy_len; end
      outmode = 0;
    end
    if (cs && sk && !sk_prev) begin
      if (outmode) begin m_do = outbuf[15]; outbuf = outbuf << 1; end
      else begin
        sreg = {sreg[23:0], di}; cnt++;
        if (cnt == 9 && sreg[8:6] == 3'b110) begin outbuf = mem[sreg[5:0]]; outmode = 1; end
        if (cnt == 9 && sreg[8:6] == 3'b100) begin
          if (sreg[5:4] == 2'b11) wen = 1;
          else if (sreg[5:4] == 2'b00) wen = 0;
        end
        if (cnt == 25 && sreg[24:22] == 3'b101 && wen) begin
          pend = 1; paddr = sreg[21:16]; pdata = sreg[15:0];
        end
      end
    end
    if (!outmode) m_do = stuck ? 1'b0 : (busy == 0);
    sk_prev = sk; cs_prev = cs;
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      checks++;
      if ({cs, sk, di} !== {ecs, esk, edi}) begin
        errors++;
        $display("FAIL %s: pins cs/sk/di=%b%b%b expected %b%b%b at cycle %0d",
                 tag, cs, sk, di, ecs, esk, edi, cyc);
      end
      checks++;
      if (ack !== eack) begin
        errors++;
        $display("FAIL R10: ack=%b expected %b at cycle %0d", ack, eack, cyc);
      end
      if (eack) begin
        checks++;
        if (rdata !== erd || tout !== eto) begin
          errors++;
          $display("FAIL R10: rdata=%h timeout=%b expected %h %b", rdata, tout, erd, eto);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // ---------------- reference sequence ----------------
  task automatic iv(input logic c, input logic s, input logic d, input bit first);
    ecs = c; esk = s; edi = d;
    if (first) begin @(negedge clk); req = 1'b0; end
    repeat (H) @(posedge clk);
  endtask

  task automatic start(input bit w, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); req = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk);
  endtask

  task automatic ref_setup();
    tag = "R2 R4"; iv(0, 0, 0, 1); iv(1, 0, 0, 0);
  endtask

  task automatic ref_shout(input logic [24:0] b, input int n);
    tag = "R2 R3";
    for (int i = n - 1; i >= 0; i--) begin
      iv(1, 0, b[i], 0); iv(1, 1, b[i], 0); iv(1, 0, b[i], 0);
    end
  endtask

  task automatic ref_shin();
    tag = "R5";
    for (int i = 0; i < 16; i++) begin iv(1, 1, 0, 0); iv(1, 0, 0, 0); end
  endtask

  task automatic ref_stby();
    tag = "R6"; iv(0, 0, 0, 0); iv(0, 1, 0, 0); iv(1, 1, 0, 0); iv(1, 0, 0, 0);
  endtask

  task automatic ref_poll(output bit to);
    tag = "R8"; to = 1;
    for (int i = 0; i < POLL_N; i++) begin
      iv(1, 0, 0, 0);
      if (m_do) begin to = 0; break; end
    end
  endtask

  task automatic ref_clean();
    tag = "R9"; iv(0, 0, 0, 0); iv(0, 1, 0, 0); iv(0, 0, 0, 0);
  endtask

  task automatic ref_done(input logic [15:0] rd, input bit to);
    tag = "R1"; ecs = 0; esk = 0; edi = 0;
    eack = 1; erd = rd; eto = to;
    @(posedge clk); eack = 0;
  endtask

  task automatic ref_read(input logic [5:0] a);
    logic [15:0] expect_d;
    expect_d = mem[a];
    start(0, a, 16'h0);
    ref_setup(); ref_shout({16'h0, 3'b110, a}, 9); ref_shin(); ref_stby();
    ref_done(expect_d, 0);
  endtask

  task automatic ref_write(input logic [5:0] a, input logic [15:0] d, output bit to);
    start(1, a, d);
    ref_setup();
    tag = "R7"; ref_shout({16'h0, 5'b10011, 4'b0000}, 9);
    ref_stby();
    ref_shout({3'b101, a, d}, 25);
    ref_stby(); ref_poll(to); ref_stby();
    ref_shout({16'h0, 5'b10000, 4'b0000}, 9);
    ref_clean();
    ref_done(16'h0, to);
  endtask

  initial begin
    bit to;
    logic [15:0] keep40;
    for (int i = 0; i < 64; i++) mem[i] = 16'h3C5A ^ 16'(i * 16'h0707);
    mem[5] = 16'hFFFF; mem[6] = 16'h0000; mem[7] = 16'h8001;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", {13'h0, cs, sk, di}, 16'h0);
    chk("R1 reset ack", {15'h0, ack}, 16'h0);
    repeat (4) @(posedge clk);

    // R5 reads at the address extremes and bit patterns
    ref_read(6'd0);
    ref_read(6'd63);
    ref_read(6'd5);
    ref_read(6'd6);
    ref_read(6'd7);
    ref_read(6'd21);

    // R7 write with ready after some polls, then read back
    busy_len = 20;
    ref_write(6'd10, 16'h1234, to);
    chk("R8 no timeout", {15'h0, to}, 16'h0);
    chk("R7 word stored", mem[10], 16'h1234);
    chk("R7 write disabled after", {15'h0, wen}, 16'h0);
    ref_read(6'd10);

    // R8 ready on the first poll sample
    busy_len = 0;
    ref_write(6'd62, 16'hA55A, to);
    chk("R8 immediate ready", {15'h0, to}, 16'h0);
    chk("R7 word stored 62", mem[62], 16'hA55A);

    // R8 never ready: timeout, sequence still completes
    stuck = 1; busy_len = 20;
    ref_write(6'd1, 16'h0F0F, to);
    chk("R8 timeout flagged", {15'h0, to}, 16'h1);
    chk("R7 write disabled after timeout", {15'h0, wen}, 16'h0);
    stuck = 0;
    repeat (40) @(posedge clk);

    // R11 request during a read is dropped; inputs latched at acceptance
    keep40 = mem[40];
    fork
      ref_read(6'd3);
      begin
        repeat (30) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 6'd40; wdata = 16'hDEAD;
        @(negedge clk); req = 1'b0;
      end
    join
    tag = "R11";
    repeat (30) @(posedge clk);
    chk("R11 no extra write", mem[40], keep40);

    // R1 back-to-back requests
    ref_read(6'd62);
    ref_read(6'd10);
    repeat (5) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule